// File: doc/BRIEF.md
# Flash Status and Write-Protect Controller

This block keeps the two status bytes of a 256 KB serial flash and decides whether each write-type request may go ahead. A command decoder in front of it turns serial opcodes into one-cycle strobes. These strobes set or clear the write-enable latch, arm a one-shot status write, write a status byte, or ask for a program or erase at an address. The block answers each status write and each program or erase request with a one-cycle grant or deny pulse. It raises the busy flag while the array timer is working, and it clears the write-enable latch when each operation finishes.

Protection is checked against the whole target range of a request. For a byte that range is one byte, for a two-byte program word it is the aligned pair, and for an erase it is the aligned 4 KB sector, the aligned 32 KB or 64 KB block, or the whole chip. A request is refused when that range overlaps the region selected by the two block-protect bits, or when it overlaps a locked top or bottom sector. A lock bit, which is honoured only while the write-protect pin is low, freezes all protection fields. A sequential program mode writes consecutive two-byte words. It keeps the latch set until the mode ends.

Top module: `fsp_status_ctrl`

## Requirements
- R1: After reset, sr0_o reads 8'h0C and sr1_o reads 8'h00. The field positions are: sr0 bit 0 busy, bit 1 write-enable latch, bits 3:2 block-protect (bp), bits 5:4 zero, bit 6 sequential-program mode, bit 7 lock. sr1 bit 2 locks the top sector, bit 3 locks the bottom sector, and all other sr1 bits are zero.
- R2: Each bp value protects a region. bp=00 protects nothing. bp=01 protects 30000h–3FFFFh. bp=10 protects 20000h–3FFFFh. bp=11 protects the whole array. A program or erase whose range touches the protected region is denied.
- R3: A chip erase (op_kind 5) is granted only when bp is 00 and neither sector lock is set.
- R4: A program or erase needs the write-enable latch. Without it the request is denied. A denied program or erase leaves the latch as it was.
- R5: A granted status write with wrsr_sel_i=0 loads lock from data bit 7 and bp from data bits 3:2. With wrsr_sel_i=1 it loads the bottom lock from data bit 3 and the top lock from data bit 2.
- R6: When wp_n_i is low and lock is 1, a status write is denied and no protection field changes. When wp_n_i is high, or lock is 0, the lock does not block the write.
- R7: The write-enable latch clears on every status write, whether granted or denied. It also clears on a write-disable strobe and on done_i ending any operation other than a sequential word.
- R8: The op_kind codes and their target ranges are: 0 = one byte; 1 = aligned two-byte word; 2 = 4 KB sector; 3 = 32 KB block; 4 = 64 KB block; 5 = whole array; 6 and 7 are always denied. Any overlap of the range with a locked top sector (3F000h–3FFFFh) or bottom sector (00000h–00FFFh) denies the request.
- R9: A grant of op_kind 0 to 5 sets busy. While busy, every strobe is ignored: no grant, no deny and no state change. done_i clears busy.
- R10: An arm strobe lets exactly one later status write through without the latch. That status write, or a write-disable strobe, consumes the arm.
- R11: A granted op_kind 1 outside the sequential mode enters it at the word of op_addr_i. Each later op_kind 1 targets the previous word plus 2, and its address input is ignored. The mode and the latch both clear on a write-disable strobe, or when done_i ends the word at 3FFFEh. Inside the mode, a status write or any other op_kind is denied.
- R12: grant_o and deny_o are one-cycle pulses in the cycle after the request, and never both high. When strobes coincide, the priority is write-disable, then write-enable, then arm, then status write, then program/erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_i | input | 1 | Set write-enable latch strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| ewsr_i | input | 1 | Arm one status write strobe |
| wrsr_i | input | 1 | Status write strobe |
| wrsr_sel_i | input | 1 | Status byte select, 0 = sr0, 1 = sr1 |
| wrsr_data_i | input | 8 | Status write data |
| op_req_i | input | 1 | Program/erase request strobe |
| op_kind_i | input | 3 | Request kind (see R8) |
| op_addr_i | input | ADDR_W | Target byte address |
| wp_n_i | input | 1 | Write-protect pin, active low |
| done_i | input | 1 | Array timer completion pulse |
| grant_o | output | 1 | Request accepted pulse |
| deny_o | output | 1 | Request refused pulse |
| sr0_o | output | 8 | Status byte 0 |
| sr1_o | output | 8 | Status byte 1 |
| wel_o | output | 1 | Write-enable latch |

## Verification
The hardest case to reach is the end of the sequential program mode at the top address. Getting there needs a latched enable, a word that starts two words below the top, and two busy/done rounds that keep the latch set between them. The bench unlocks the array first, then starts a word at 3FFFCh, finishes it, issues a continuation with a deliberately wrong address, and checks that the final done clears both the mode bit and the latch. The locked state with the write-protect pin low is reached the same way: a granted write sets lock while the pin is high, and the pin is then pulled low.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [2:0] {
    OP_BYTE = 3'd0,
    OP_WORD = 3'd1,
    OP_SEC  = 3'd2,
    OP_B32  = 3'd3,
    OP_B64  = 3'd4,
    OP_CHIP = 3'd5
  } op_kind_e;

  localparam int unsigned SR0_LOCK = 7;
  localparam int unsigned SR0_BP_H = 3;
  localparam int unsigned SR0_BP_L = 2;
  localparam int unsigned SR1_BOT  = 3;
  localparam int unsigned SR1_TOP  = 2;
endpackage

// File: rtl/fsp_range_calc.sv
module fsp_range_calc #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned SEC_W  = 12,
  parameter int unsigned B32_W  = 15,
  parameter int unsigned B64_W  = 16
) (
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_on_i,
  input  logic [ADDR_W-1:0] word_base_i,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o,
  output logic              valid_o
);
  import fsp_pkg::*;

  localparam logic [ADDR_W-1:0] ONES = '1;
  localparam int unsigned N_ER = 3;
  localparam int unsigned ER_W [N_ER] = '{SEC_W, B32_W, B64_W};

  logic [ADDR_W-1:0] er_lo [N_ER];
  logic [ADDR_W-1:0] er_hi [N_ER];
  logic [ADDR_W-1:0] word_lo;

  for (genvar g = 0; g < N_ER; g++) begin : g_erase
    localparam logic [ADDR_W-1:0] MASK = ONES << ER_W[g];
    assign er_lo[g] = addr_i & MASK;
    assign er_hi[g] = addr_i | ~MASK;
  end

  // Continuation words step from the previous word; first word aligns input.
  assign word_lo = word_on_i ? (word_base_i + ADDR_W'(2)) : (addr_i & (ONES << 1));

  always_comb begin
    lo_o    = '0;
    hi_o    = ONES;
    valid_o = 1'b1;
    case (kind_i)
      OP_BYTE: begin lo_o = addr_i;   hi_o = addr_i;          end
      OP_WORD: begin lo_o = word_lo;  hi_o = word_lo | ADDR_W'(1); end
      OP_SEC:  begin lo_o = er_lo[0]; hi_o = er_hi[0];        end
      OP_B32:  begin lo_o = er_lo[1]; hi_o = er_hi[1];        end
      OP_B64:  begin lo_o = er_lo[2]; hi_o = er_hi[2];        end
      OP_CHIP: begin lo_o = '0;       hi_o = ONES;            end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsp_prot_check.sv
module fsp_prot_check #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned SEC_W  = 12
) (
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [1:0]        bp_i,
  input  logic              top_lock_i,
  input  logic              bot_lock_i,
  output logic              blocked_o
);
  localparam logic [ADDR_W-1:0] ONES       = '1;
  localparam logic [ADDR_W-1:0] QUART_BASE = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] HALF_BASE  = {2'b10, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] TOP_SEC    = ONES << SEC_W;

  logic [ADDR_W-1:0] prot_lo;
  logic bp_hit, top_hit, bot_hit;

  always_comb begin
    case (bp_i)
      2'b01:   prot_lo = QUART_BASE;
      2'b10:   prot_lo = HALF_BASE;
      default: prot_lo = '0;
    endcase
  end

  // Every protected region ends at the top address, so overlap needs only hi.
  assign bp_hit    = (bp_i != 2'b00) && (hi_i >= prot_lo);
  assign top_hit   = top_lock_i && (hi_i >= TOP_SEC);
  assign bot_hit   = bot_lock_i && (lo_i[ADDR_W-1:SEC_W] == '0);
  assign blocked_o = bp_hit | top_hit | bot_hit;
endmodule

// File: rtl/fsp_wsr_gate.sv
module fsp_wsr_gate (
  input  logic       wp_n_i,
  input  logic       lock_i,
  input  logic       wel_i,
  input  logic       arm_i,
  input  logic       sel_i,
  input  logic [7:0] data_i,
  input  logic [1:0] bp_i,
  input  logic       top_i,
  input  logic       bot_i,
  output logic       ok_o,
  output logic [1:0] bp_o,
  output logic       lock_o,
  output logic       top_o,
  output logic       bot_o
);
  import fsp_pkg::*;

  assign ok_o = (wel_i | arm_i) & ~(~wp_n_i & lock_i);

  always_comb begin
    bp_o   = bp_i;
    lock_o = lock_i;
    top_o  = top_i;
    bot_o  = bot_i;
    if (!sel_i) begin
      bp_o   = data_i[SR0_BP_H:SR0_BP_L];
      lock_o = data_i[SR0_LOCK];
    end else begin
      top_o  = data_i[SR1_TOP];
      bot_o  = data_i[SR1_BOT];
    end
  end
endmodule

// File: rtl/fsp_status_ctrl.sv
module fsp_status_ctrl #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned SEC_W  = 12,
  parameter int unsigned B32_W  = 15,
  parameter int unsigned B64_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              ewsr_i,
  input  logic              wrsr_i,
  input  logic              wrsr_sel_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              op_req_i,
  input  logic [2:0]        op_kind_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              wp_n_i,
  input  logic              done_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic [7:0]        sr0_o,
  output logic [7:0]        sr1_o,
  output logic              wel_o
);
  import fsp_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_WORD = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic              busy_q, wel_q, word_q, arm_q, lock_q, top_q, bot_q;
  logic [1:0]        bp_q;
  logic [ADDR_W-1:0] word_addr_q;

  logic [ADDR_W-1:0] rng_lo, rng_hi;
  logic              kind_ok, blocked;
  logic              wsr_ok, lock_n, top_n, bot_n;
  logic [1:0]        bp_n;

  fsp_range_calc #(
    .ADDR_W(ADDR_W), .SEC_W(SEC_W), .B32_W(B32_W), .B64_W(B64_W)
  ) u_range (
    .kind_i      (op_kind_i),
    .addr_i      (op_addr_i),
    .word_on_i   (word_q),
    .word_base_i (word_addr_q),
    .lo_o        (rng_lo),
    .hi_o        (rng_hi),
    .valid_o     (kind_ok)
  );

  fsp_prot_check #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_prot (
    .lo_i       (rng_lo),
    .hi_i       (rng_hi),
    .bp_i       (bp_q),
    .top_lock_i (top_q),
    .bot_lock_i (bot_q),
    .blocked_o  (blocked)
  );

  fsp_wsr_gate u_gate (
    .wp_n_i (wp_n_i),
    .lock_i (lock_q),
    .wel_i  (wel_q),
    .arm_i  (arm_q),
    .sel_i  (wrsr_sel_i),
    .data_i (wrsr_data_i),
    .bp_i   (bp_q),
    .top_i  (top_q),
    .bot_i  (bot_q),
    .ok_o   (wsr_ok),
    .bp_o   (bp_n),
    .lock_o (lock_n),
    .top_o  (top_n),
    .bot_o  (bot_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      wel_q       <= 1'b0;
      word_q      <= 1'b0;
      arm_q       <= 1'b0;
      lock_q      <= 1'b0;
      top_q       <= 1'b0;
      bot_q       <= 1'b0;
      bp_q        <= 2'b11;
      word_addr_q <= '0;
      grant_o     <= 1'b0;
      deny_o      <= 1'b0;
    end else begin
      grant_o <= 1'b0;
      deny_o  <= 1'b0;
      if (busy_q) begin
        // Array operation in flight: only completion matters.
        if (done_i) begin
          busy_q <= 1'b0;
          if (!word_q) begin
            wel_q <= 1'b0;
          end else if (word_addr_q == LAST_WORD) begin
            word_q <= 1'b0;
            wel_q  <= 1'b0;
          end
        end
      end else if (wrdi_i) begin
        wel_q  <= 1'b0;
        arm_q  <= 1'b0;
        word_q <= 1'b0;
      end else if (word_q) begin
        if (op_req_i && (op_kind_i == OP_WORD)) begin
          if (blocked) begin
            deny_o <= 1'b1;
          end else begin
            grant_o     <= 1'b1;
            busy_q      <= 1'b1;
            word_addr_q <= rng_lo;
          end
        end else if (wrsr_i || op_req_i) begin
          deny_o <= 1'b1;
        end
      end else if (wren_i) begin
        wel_q <= 1'b1;
      end else if (ewsr_i) begin
        arm_q <= 1'b1;
      end else if (wrsr_i) begin
        wel_q <= 1'b0;
        arm_q <= 1'b0;
        if (wsr_ok) begin
          grant_o <= 1'b1;
          bp_q    <= bp_n;
          lock_q  <= lock_n;
          top_q   <= top_n;
          bot_q   <= bot_n;
        end else begin
          deny_o <= 1'b1;
        end
      end else if (op_req_i) begin
        if (wel_q && kind_ok && !blocked) begin
          grant_o <= 1'b1;
          busy_q  <= 1'b1;
          if (op_kind_i == OP_WORD) begin
            word_q      <= 1'b1;
            word_addr_q <= rng_lo;
          end
        end else begin
          deny_o <= 1'b1;
        end
      end
    end
  end

  assign sr0_o = {lock_q, word_q, 2'b00, bp_q, wel_q, busy_q};
  assign sr1_o = {4'b0000, bot_q, top_q, 2'b00};
  assign wel_o = wel_q;
endmodule

// File: rtl/fsp_status_ctrl_chk.sv
module fsp_status_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic       ewsr_i,
  input logic       wrsr_i,
  input logic       op_req_i,
  input logic [2:0] op_kind_i,
  input logic       wp_n_i,
  input logic       done_i,
  input logic       grant_o,
  input logic       deny_o,
  input logic [7:0] sr0_o,
  input logic [7:0] sr1_o,
  input logic       wel_o
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sr0_o == 8'h0C) && (sr1_o == 8'h00));

  a_r12_one_answer: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && deny_o));

  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(sr0_o[0]) |-> !grant_o && !deny_o);

  a_r4_grant_needs_wel: assert property (@(posedge clk) disable iff (rst)
    (grant_o && $past(op_req_i) && !$past(wrdi_i || wren_i || ewsr_i || wrsr_i))
      |-> $past(wel_o));

  a_r3_chip_clear_bp: assert property (@(posedge clk) disable iff (rst)
    (grant_o && $past(op_req_i && op_kind_i == 3'd5)
       && !$past(wrdi_i || wren_i || ewsr_i || wrsr_i))
      |-> ($past(sr0_o[3:2]) == 2'b00));

  a_r6_locked_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!wp_n_i && sr0_o[7]) && !$past(rst))
      |-> sr0_o[7] && (sr0_o[3:2] == $past(sr0_o[3:2])) && (sr1_o == $past(sr1_o)));

  a_r7_wel_clear_done: assert property (@(posedge clk) disable iff (rst)
    ($past(sr0_o[0] && done_i && !sr0_o[6]) && !$past(rst)) |-> !wel_o);
endmodule

bind fsp_status_ctrl fsp_status_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wren_i    (wren_i),
  .wrdi_i    (wrdi_i),
  .ewsr_i    (ewsr_i),
  .wrsr_i    (wrsr_i),
  .op_req_i  (op_req_i),
  .op_kind_i (op_kind_i),
  .wp_n_i    (wp_n_i),
  .done_i    (done_i),
  .grant_o   (grant_o),
  .deny_o    (deny_o),
  .sr0_o     (sr0_o),
  .sr1_o     (sr1_o),
  .wel_o     (wel_o)
);

// File: tb/fsp_status_ctrl_tb.sv
module fsp_status_ctrl_tb;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wren_i = 0, wrdi_i = 0, ewsr_i = 0, wrsr_i = 0, wrsr_sel_i = 0;
  logic [7:0]        wrsr_data_i = '0;
  logic              op_req_i = 0;
  logic [2:0]        op_kind_i = '0;
  logic [ADDR_W-1:0] op_addr_i = '0;
  logic              wp_n_i = 1'b1;
  logic              done_i = 1'b0;
  logic              grant_o, deny_o, wel_o;
  logic [7:0]        sr0_o, sr1_o;

  always #2 clk = ~clk;

  fsp_status_ctrl u_dut (.*);

  typedef struct {
    string tag;
    bit    g;
    bit    d;
    int    due;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares responses when they fall due.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (grant_o !== it.g || deny_o !== it.d) begin
        n_bad++;
        $display("FAIL %s: grant/deny actual %b%b expected %b%b",
                 it.tag, grant_o, deny_o, it.g, it.d);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(input string tag, input bit g, input bit d);
    item_t it;
    it.tag = tag; it.g = g; it.d = d; it.due = cyc + 1;
    q.push_back(it);
    @(negedge clk);
    wren_i = 0; wrdi_i = 0; ewsr_i = 0; wrsr_i = 0; op_req_i = 0; done_i = 0;
  endtask

  task automatic t_wren(input string tag);
    wren_i = 1; pulse(tag, 0, 0);
  endtask
  task automatic t_wrdi(input string tag);
    wrdi_i = 1; pulse(tag, 0, 0);
  endtask
  task automatic t_ewsr(input string tag);
    ewsr_i = 1; pulse(tag, 0, 0);
  endtask
  task automatic t_done(input string tag);
    done_i = 1; pulse(tag, 0, 0);
  endtask
  task automatic t_wrsr(input string tag, input bit sel, input logic [7:0] dat,
                        input bit g, input bit d);
    wrsr_i = 1; wrsr_sel_i = sel; wrsr_data_i = dat; pulse(tag, g, d);
  endtask
  task automatic t_op(input string tag, input logic [2:0] kind,
                      input logic [ADDR_W-1:0] addr, input bit g, input bit d);
    op_req_i = 1; op_kind_i = kind; op_addr_i = addr; pulse(tag, g, d);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 sr0 reset", sr0_o, 8'h0C);
    chk("R1 sr1 reset", sr1_o, 8'h00);
    chk("R1 wel reset", {7'd0, wel_o}, 8'h00);

    t_op("R4 byte without latch", 3'd0, 18'h00000, 0, 1);
    t_wren("R4 wren");
    chk("R4 latch set", sr0_o, 8'h0E);
    t_wrsr("R5 clear bp", 0, 8'h00, 1, 0);
    chk("R7 wrsr clears latch", sr0_o, 8'h00);

    t_wren("R9 wren");
    t_op("R2 byte unprotected top", 3'd0, 18'h3FFFF, 1, 0);
    chk("R9 busy set", sr0_o, 8'h03);
    t_wren("R9 wren ignored");
    t_wrsr("R9 wrsr ignored", 0, 8'h0C, 0, 0);
    t_op("R9 op ignored", 3'd2, 18'h00000, 0, 0);
    chk("R9 state held while busy", sr0_o, 8'h03);
    t_done("R7 done");
    chk("R7 latch clears on done", sr0_o, 8'h00);

    t_wren("R2 wren");
    t_wrsr("R2 bp01", 0, 8'h04, 1, 0);
    chk("R5 bp01 loaded", sr0_o, 8'h04);
    t_wren("R2 wren");
    t_op("R2 sector below quarter", 3'd2, 18'h2F000, 1, 0);
    t_done("R2 done");
    t_wren("R2 wren");
    t_op("R2 sector in quarter", 3'd2, 18'h30000, 0, 1);
    chk("R4 deny keeps latch", sr0_o, 8'h06);
    t_op("R8 64K below quarter", 3'd4, 18'h20000, 1, 0);
    t_done("R2 done");
    chk("R2 after 64K", sr0_o, 8'h04);

    t_wren("R2 wren");
    t_wrsr("R2 bp10", 0, 8'h08, 1, 0);
    t_wren("R2 wren");
    t_op("R8 32K below half", 3'd3, 18'h18000, 1, 0);
    t_done("R2 done");
    t_wren("R2 wren");
    t_op("R2 64K in half", 3'd4, 18'h2ABCD, 0, 1);
    t_op("R3 chip with bp10", 3'd5, 18'h00000, 0, 1);
    chk("R2 state", sr0_o, 8'h0A);
    t_wrsr("R5 clear bp", 0, 8'h00, 1, 0);
    t_wren("R3 wren");
    t_op("R3 chip unprotected", 3'd5, 18'h00000, 1, 0);
    t_done("R3 done");
    t_op("R8 kind 6", 3'd6, 18'h00000, 0, 1);

    t_wren("R8 wren");
    t_wrsr("R5 top lock", 1, 8'h04, 1, 0);
    chk("R5 sr1 top", sr1_o, 8'h04);
    t_wren("R8 wren");
    t_op("R8 byte in top sector", 3'd0, 18'h3F123, 0, 1);
    t_op("R8 sector below top", 3'd2, 18'h3E000, 1, 0);
    t_done("R8 done");
    t_wren("R3 wren");
    t_op("R3 chip with top lock", 3'd5, 18'h00000, 0, 1);
    t_wrsr("R5 bottom lock", 1, 8'h08, 1, 0);
    chk("R5 sr1 bottom", sr1_o, 8'h08);
    t_wren("R8 wren");
    t_op("R8 byte in bottom sector", 3'd0, 18'h00FFF, 0, 1);
    t_op("R8 byte above bottom", 3'd0, 18'h01000, 1, 0);
    t_done("R8 done");

    t_wren("R6 wren");
    t_wrsr("R6 set lock", 0, 8'h84, 1, 0);
    chk("R6 lock set", sr0_o, 8'h84);
    wp_n_i = 1'b0;
    t_wren("R6 wren");
    t_wrsr("R6 locked sr0", 0, 8'h00, 0, 1);
    chk("R6 sr0 frozen", sr0_o, 8'h84);
    t_wren("R6 wren");
    t_wrsr("R6 locked sr1", 1, 8'h00, 0, 1);
    chk("R6 sr1 frozen", sr1_o, 8'h08);
    wp_n_i = 1'b1;
    t_wren("R6 wren");
    t_wrsr("R6 pin high unlock", 0, 8'h00, 1, 0);
    t_wren("R6 wren");
    t_wrsr("R6 clear sr1", 1, 8'h00, 1, 0);
    wp_n_i = 1'b0;
    t_wren("R6 wren");
    t_wrsr("R6 pin low lock clear", 0, 8'h04, 1, 0);
    chk("R6 written with pin low", sr0_o, 8'h04);
    wp_n_i = 1'b1;

    t_ewsr("R10 arm");
    t_wrsr("R10 armed write", 0, 8'h0C, 1, 0);
    chk("R10 armed result", sr0_o, 8'h0C);
    t_wrsr("R10 arm consumed", 0, 8'h00, 0, 1);
    t_wren("R10 wren");
    t_wrsr("R10 clear bp", 0, 8'h00, 1, 0);

    t_wren("R11 wren");
    t_op("R11 first word", 3'd1, 18'h3FFFC, 1, 0);
    chk("R11 mode busy", sr0_o, 8'h43);
    t_done("R11 done");
    chk("R11 mode keeps latch", sr0_o, 8'h42);
    t_wrsr("R11 wrsr in mode", 0, 8'h0C, 0, 1);
    t_op("R11 sector in mode", 3'd2, 18'h00000, 0, 1);
    chk("R11 mode unchanged", sr0_o, 8'h42);
    t_op("R11 next word", 3'd1, 18'h00000, 1, 0);
    t_done("R11 last done");
    chk("R11 top word ends mode", sr0_o, 8'h00);
    t_wren("R11 wren");
    t_op("R11 word start", 3'd1, 18'h00101, 1, 0);
    t_done("R11 done");
    t_wrdi("R11 wrdi exit");
    chk("R11 wrdi ends mode", sr0_o, 8'h00);

    wren_i = 1; wrdi_i = 1;
    pulse("R12 priority", 0, 0);
    chk("R12 wrdi wins", {7'd0, wel_o}, 8'h00);

    repeat (2) @(negedge clk);
    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R12: actual %0d pending expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule